// File: doc/BRIEF.md
# Shadow Address Translation Cache

A small fully associative translation cache placed in front of a main TLB. Each lookup presents a 64-bit effective address and the address-space bit of the current machine state. The cache compares the effective page number and the address-space bit against every stored entry in parallel. On a single match it returns the 42-bit real address and the execute, read and write permission bits of that entry. The in-page offset passes straight through.

When no entry matches, the block pulses a miss request that carries the page number and address-space bit toward the queue that serves the main TLB. The block never produces a missing translation itself. Some cycles later the main TLB answers through the fill port, and the fill overwrites the least-recently-used entry. A force-real control skips translation entirely, and an invalidate-all input empties the cache in one cycle.

Out of reset the cache holds exactly one valid entry. That entry maps the highest page of the effective space to the highest page of the real space, so that start-up code can fetch before any fill has happened.

Top module: `xlat_shadow`

## Requirements
- R1: Reset state. After reset exactly one entry is valid. It has page number all ones, address-space bit 0, real page number all ones and permissions 3'b111. A lookup of any address in that page with address-space bit 0 hits, and its real address is {all-ones real page, ea[11:0]}.
- R2: Hit rule. A lookup hits only when both the effective page number (ea[63:12]) and the address-space bit equal those of a valid entry. The result appears one cycle after the request: rsp_valid=1, rsp_hit=1, rsp_ra={entry real page, ea[11:0]}. rsp_perm comes from the entry, with bit 2 = execute, bit 1 = read and bit 0 = write.
- R3: Miss. A lookup with no matching entry gives rsp_hit=0. In the same response cycle it gives miss_req=1, with miss_epn=ea[63:12] and miss_as equal to the looked-up address-space bit.
- R4: Force real. A lookup with force_real=1 gives rsp_hit=1, rsp_ra=ea[41:0], rsp_perm=3'b111 and miss_req=0. It leaves the replacement order unchanged.
- R5: Fill. A fill writes the entry that is least recently used, marks it valid and makes it most recently used. Starting from reset, the first 31 fills never displace the reset entry.
- R6: A lookup that hits makes its entry most recently used in the same cycle. When a fill occurs in the same cycle, the fill's entry takes that position instead.
- R7: Multihit. If two or more valid entries match, the response has rsp_multihit=1, rsp_hit=0 and miss_req=0.
- R8: Invalidate-all clears every valid bit in one cycle, including the reset entry. A fill presented in the same cycle as invalidate-all is dropped.
- R9: A cycle without a lookup request produces rsp_valid=0, rsp_hit=0 and miss_req=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 64 | Effective address to translate |
| lk_as | input | 1 | Address-space bit of the current machine state |
| force_real | input | 1 | Skip translation; real address taken from effective address |
| inv_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Translation returned by the main TLB |
| fill_epn | input | 52 | Effective page number of the fill |
| fill_as | input | 1 | Address-space bit of the fill |
| fill_rpn | input | 30 | Real page number of the fill |
| fill_perm | input | 3 | Permissions of the fill {execute, read, write} |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Translation found (or forced real) |
| rsp_ra | output | 42 | Real address |
| rsp_perm | output | 3 | Permissions {execute, read, write} |
| rsp_multihit | output | 1 | More than one entry matched |
| miss_req | output | 1 | Request toward the main TLB miss queue |
| miss_epn | output | 52 | Page number of the missed lookup |
| miss_as | output | 1 | Address-space bit of the missed lookup |

## Verification
The bench builds the block with its default parameters: 32 entries, 4 KB pages, 64-bit effective and 42-bit real addresses. With those values, filling 31 fresh pages from reset brings the replacement order to the exact point where the next fill would evict the reset entry. A single hit on the reset entry then shows that the victim moves to the oldest fill. The bench also models the main TLB, which answers each miss after 19 cycles. Its vector walk pairs pages that differ only in the address-space bit, so that key separation is exercised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PERM_W    = 3;
  localparam int PERM_X    = 2;
  localparam int PERM_R    = 1;
  localparam int PERM_WR   = 0;
  localparam logic [PERM_W-1:0] PERM_SUP_ALL = 3'b111;
endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int N       = 32,
  parameter int EPN_W   = 52,
  parameter int RPN_W   = 30,
  parameter int RST_IDX = 0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inv_all,
  input  logic                         wr_en,
  input  logic [$clog2(N)-1:0]         wr_idx,
  input  logic [EPN_W-1:0]             wr_epn,
  input  logic                         wr_as,
  input  logic [RPN_W-1:0]             wr_rpn,
  input  logic [xlat_pkg::PERM_W-1:0]  wr_perm,
  output logic [N-1:0]                 vld,
  output logic [N-1:0][EPN_W-1:0]      epn,
  output logic [N-1:0]                 as_bit,
  output logic [N-1:0][RPN_W-1:0]      rpn,
  output logic [N-1:0][xlat_pkg::PERM_W-1:0] perm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        vld[i]    <= (i == RST_IDX);
        epn[i]    <= (i == RST_IDX) ? '1 : '0;
        as_bit[i] <= 1'b0;
        rpn[i]    <= (i == RST_IDX) ? '1 : '0;
        perm[i]   <= (i == RST_IDX) ? xlat_pkg::PERM_SUP_ALL : '0;
      end
    end else if (inv_all) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx]    <= 1'b1;
      epn[wr_idx]    <= wr_epn;
      as_bit[wr_idx] <= wr_as;
      rpn[wr_idx]    <= wr_rpn;
      perm[wr_idx]   <= wr_perm;
    end
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N     = 32,
  parameter int EPN_W = 52
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][EPN_W-1:0] epn,
  input  logic [N-1:0]            as_bit,
  input  logic [EPN_W-1:0]        key_epn,
  input  logic                    key_as,
  output logic                    match_any,
  output logic                    match_multi,
  output logic [$clog2(N)-1:0]    match_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (epn[g] == key_epn) && (as_bit[g] == key_as);
  end

  assign match_any   = |match;
  assign match_multi = |(match & (match - 1'b1));

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) match_idx = ($clog2(N))'(i);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch_en,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] victim
);
  localparam int IW = $clog2(N);
  logic [IW-1:0] age [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IW'(N - 1)) victim = IW'(i);
  end
endmodule

// File: rtl/xlat_shadow.sv
module xlat_shadow #(
  parameter int EA_W    = 64,
  parameter int RA_W    = 42,
  parameter int PG_W    = 12,
  parameter int ENTRIES = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lk_valid,
  input  logic [EA_W-1:0]             lk_ea,
  input  logic                        lk_as,
  input  logic                        force_real,
  input  logic                        inv_all,
  input  logic                        fill_valid,
  input  logic [EA_W-PG_W-1:0]        fill_epn,
  input  logic                        fill_as,
  input  logic [RA_W-PG_W-1:0]        fill_rpn,
  input  logic [xlat_pkg::PERM_W-1:0] fill_perm,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic [RA_W-1:0]             rsp_ra,
  output logic [xlat_pkg::PERM_W-1:0] rsp_perm,
  output logic                        rsp_multihit,
  output logic                        miss_req,
  output logic [EA_W-PG_W-1:0]        miss_epn,
  output logic                        miss_as
);
  localparam int EPN_W = EA_W - PG_W;
  localparam int RPN_W = RA_W - PG_W;
  localparam int IW    = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             e_vld, e_as;
  logic [ENTRIES-1:0][EPN_W-1:0]  e_epn;
  logic [ENTRIES-1:0][RPN_W-1:0]  e_rpn;
  logic [ENTRIES-1:0][xlat_pkg::PERM_W-1:0] e_perm;
  logic             m_any, m_multi;
  logic [IW-1:0]    m_idx, victim, touch_idx;
  logic             look_act, look_hit, fill_go, touch_en;
  logic [EPN_W-1:0] key_epn;

  assign key_epn   = lk_ea[EA_W-1:PG_W];
  assign look_act  = lk_valid && !force_real;
  assign look_hit  = look_act && m_any && !m_multi;
  assign fill_go   = fill_valid && !inv_all;
  assign touch_en  = fill_go || look_hit;
  assign touch_idx = fill_go ? victim : m_idx;

  xlat_store #(.N(ENTRIES), .EPN_W(EPN_W), .RPN_W(RPN_W), .RST_IDX(0)) u_store (
    .clk(clk), .rst(rst), .inv_all(inv_all), .wr_en(fill_go), .wr_idx(victim),
    .wr_epn(fill_epn), .wr_as(fill_as), .wr_rpn(fill_rpn), .wr_perm(fill_perm),
    .vld(e_vld), .epn(e_epn), .as_bit(e_as), .rpn(e_rpn), .perm(e_perm));

  xlat_cam #(.N(ENTRIES), .EPN_W(EPN_W)) u_cam (
    .vld(e_vld), .epn(e_epn), .as_bit(e_as), .key_epn(key_epn), .key_as(lk_as),
    .match_any(m_any), .match_multi(m_multi), .match_idx(m_idx));

  xlat_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx), .victim(victim));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_ra       <= '0;
      rsp_perm     <= '0;
      rsp_multihit <= 1'b0;
      miss_req     <= 1'b0;
      miss_epn     <= '0;
      miss_as      <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_multihit <= look_act && m_multi;
      miss_req     <= look_act && !m_any;
      miss_epn     <= key_epn;
      miss_as      <= lk_as;
      if (lk_valid && force_real) begin
        rsp_hit  <= 1'b1;
        rsp_ra   <= lk_ea[RA_W-1:0];
        rsp_perm <= xlat_pkg::PERM_SUP_ALL;
      end else if (look_hit) begin
        rsp_hit  <= 1'b1;
        rsp_ra   <= {e_rpn[m_idx], lk_ea[PG_W-1:0]};
        rsp_perm <= e_perm[m_idx];
      end else begin
        rsp_hit  <= 1'b0;
        rsp_ra   <= '0;
        rsp_perm <= '0;
      end
    end
  end
endmodule

module xlat_shadow_chk #(
  parameter int EA_W = 64,
  parameter int RA_W = 42
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [EA_W-1:0] lk_ea,
  input logic            force_real,
  input logic            inv_all,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [RA_W-1:0] rsp_ra,
  input logic            rsp_multihit,
  input logic            miss_req
);
  p_miss_not_hit_r3: assert property (@(posedge clk) disable iff (rst)
    miss_req |-> !rsp_hit);

  p_force_real_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && force_real) |=> (rsp_hit && !miss_req && rsp_ra == $past(lk_ea[RA_W-1:0])));

  p_multihit_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_multihit |-> (!rsp_hit && !miss_req));

  p_inv_empty_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_all) && lk_valid && !force_real) |=> !rsp_hit);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !miss_req));

  p_outcome_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, miss_req, rsp_multihit}));
endmodule

bind xlat_shadow xlat_shadow_chk #(.EA_W(EA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ea(lk_ea), .force_real(force_real),
  .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra),
  .rsp_multihit(rsp_multihit), .miss_req(miss_req));

// File: tb/sim_xlat_shadow.sv
`timescale 1ns/1ps
module sim_xlat_shadow;
  localparam int EA_W = 64, RA_W = 42, PG_W = 12, ENTRIES = 32;
  localparam int EPN_W = EA_W - PG_W, RPN_W = RA_W - PG_W;
  localparam int MISS_LAT = 19;
  localparam int NVEC = 6;
  localparam logic [EA_W-1:0] VEC_EA [NVEC] = '{
    64'h0000_0000_1234_5678, 64'h0000_0000_1234_5ABC, 64'hFFFF_FFFF_FFFF_F010,
    64'h8000_0000_0000_0FFF, 64'h0123_4567_89AB_C000, 64'h0000_0000_0000_0004};
  localparam logic VEC_AS [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 0, rst = 1;
  logic lk_valid = 0, lk_as = 0, force_real = 0, inv_all = 0;
  logic [EA_W-1:0] lk_ea = '0;
  logic fill_valid = 0, fill_as = 0;
  logic [EPN_W-1:0] fill_epn = '0;
  logic [RPN_W-1:0] fill_rpn = '0;
  logic [2:0] fill_perm = '0;
  logic rsp_valid, rsp_hit, rsp_multihit, miss_req, miss_as;
  logic [RA_W-1:0] rsp_ra;
  logic [2:0] rsp_perm;
  logic [EPN_W-1:0] miss_epn;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic r_valid, r_hit, r_mh, r_miss, r_mas;
  logic [RA_W-1:0] r_ra;
  logic [2:0] r_perm;
  logic [EPN_W-1:0] r_mepn;
  localparam logic [EA_W-1:0] RST_PAGE = 64'hFFFF_FFFF_FFFF_F123;

  always #2.5 clk = ~clk;

  xlat_shadow #(.EA_W(EA_W), .RA_W(RA_W), .PG_W(PG_W), .ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_as(lk_as),
    .force_real(force_real), .inv_all(inv_all), .fill_valid(fill_valid),
    .fill_epn(fill_epn), .fill_as(fill_as), .fill_rpn(fill_rpn), .fill_perm(fill_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra), .rsp_perm(rsp_perm),
    .rsp_multihit(rsp_multihit), .miss_req(miss_req), .miss_epn(miss_epn), .miss_as(miss_as));

  function automatic logic [RPN_W-1:0] tlb_rpn(logic [EPN_W-1:0] e);
    return e[RPN_W-1:0] ^ 30'h2A5A_5A5A;
  endfunction
  function automatic logic [2:0] tlb_perm(logic [EPN_W-1:0] e);
    return e[2:0] | 3'b010;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic lookup(input logic [EA_W-1:0] ea, input logic as_b, input logic fr);
    @(negedge clk);
    lk_valid = 1; lk_ea = ea; lk_as = as_b; force_real = fr;
    @(negedge clk);
    lk_valid = 0; force_real = 0;
    r_valid = rsp_valid; r_hit = rsp_hit; r_ra = rsp_ra; r_perm = rsp_perm;
    r_mh = rsp_multihit; r_miss = miss_req; r_mepn = miss_epn; r_mas = miss_as;
  endtask

  task automatic fill(input logic [EPN_W-1:0] e, input logic as_b, input logic with_inv);
    @(negedge clk);
    fill_valid = 1; fill_epn = e; fill_as = as_b; fill_rpn = tlb_rpn(e);
    fill_perm = tlb_perm(e); inv_all = with_inv;
    @(negedge clk);
    fill_valid = 0; inv_all = 0;
  endtask

  task automatic serve_miss(input logic [EPN_W-1:0] e, input logic as_b);
    repeat (MISS_LAT - 2) @(negedge clk);
    fill(e, as_b, 1'b0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [EPN_W-1:0] e;
    logic [RA_W-1:0] exp_ra;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !miss_req, "R9 idle after reset", {rsp_valid, rsp_hit, miss_req}, 0);

    // R1 reset entry
    lookup(RST_PAGE, 1'b0, 1'b0);
    chk(r_hit && r_ra == 42'h3FF_FFFF_F123, "R1 reset page ra", r_ra, 42'h3FF_FFFF_F123);
    chk(r_perm == 3'b111 && r_valid, "R1 reset page perm", r_perm, 3'b111);

    // R4 force real
    lookup(64'h0000_0ABC_DEF0_1357, 1'b1, 1'b1);
    chk(r_hit && !r_miss && r_ra == 42'h2BC_DEF0_1357, "R4 force real ra", r_ra, 42'h2BC_DEF0_1357);
    chk(r_perm == 3'b111, "R4 force real perm", r_perm, 3'b111);

    // vector walk: miss, 19-cycle main TLB answer, hit (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      e = VEC_EA[v][EA_W-1:PG_W];
      lookup(VEC_EA[v], VEC_AS[v], 1'b0);
      chk(r_miss && !r_hit, "R3 miss raised", {r_miss, r_hit}, 2'b10);
      chk(r_mepn == e && r_mas == VEC_AS[v], "R3 miss key", {r_mepn, r_mas}, {e, VEC_AS[v]});
      serve_miss(e, VEC_AS[v]);
      lookup(VEC_EA[v], VEC_AS[v], 1'b0);
      exp_ra = {tlb_rpn(e), VEC_EA[v][PG_W-1:0]};
      chk(r_hit && r_ra == exp_ra, "R2 hit ra after fill", r_ra, exp_ra);
      chk(r_perm == tlb_perm(e), "R2 hit perm", r_perm, tlb_perm(e));
    end
    lookup(64'h0000_0000_1234_5000, 1'b1, 1'b0);
    chk(r_hit && r_ra == {tlb_rpn(52'h12345), 12'h000}, "R2 as-bit selects entry", r_ra, {tlb_rpn(52'h12345), 12'h000});

    // R5/R6 replacement order
    do_reset();
    for (int k = 1; k <= 31; k++) fill(EPN_W'(100 + k), 1'b0, 1'b0);
    lookup(RST_PAGE, 1'b0, 1'b0);
    chk(r_hit, "R5 reset entry survives 31 fills", r_hit, 1);
    fill(EPN_W'(200), 1'b0, 1'b0);
    lookup({EPN_W'(101), 12'h000}, 1'b0, 1'b0);
    chk(!r_hit && r_miss, "R6 oldest fill evicted", r_hit, 0);
    lookup({EPN_W'(102), 12'h000}, 1'b0, 1'b0);
    chk(r_hit, "R5 next fill kept", r_hit, 1);
    lookup({EPN_W'(200), 12'h000}, 1'b0, 1'b0);
    chk(r_hit, "R5 new fill present", r_hit, 1);
    lookup(RST_PAGE, 1'b0, 1'b0);
    chk(r_hit, "R6 touched reset entry kept", r_hit, 1);

    // R7 multihit
    fill(EPN_W'(300), 1'b1, 1'b0);
    fill(EPN_W'(300), 1'b1, 1'b0);
    lookup({EPN_W'(300), 12'h0AB}, 1'b1, 1'b0);
    chk(r_mh && !r_hit && !r_miss, "R7 multihit", {r_mh, r_hit, r_miss}, 3'b100);

    // R8 invalidate-all
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    lookup(RST_PAGE, 1'b0, 1'b0);
    chk(!r_hit && r_miss, "R8 reset entry cleared", r_hit, 0);
    lookup({EPN_W'(300), 12'h0AB}, 1'b1, 1'b0);
    chk(!r_mh && r_miss, "R8 duplicates cleared", {r_mh, r_miss}, 2'b01);
    fill(EPN_W'(400), 1'b0, 1'b1);
    lookup({EPN_W'(400), 12'h000}, 1'b0, 1'b0);
    chk(!r_hit && r_miss, "R8 fill dropped with inv", r_hit, 0);

    // R9 no request
    @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !miss_req, "R9 idle response", {rsp_valid, rsp_hit, miss_req}, 0);

    finish_run();
  end
endmodule